// File: doc/BRIEF.md
# Filter Coefficient Download Loader

This block takes a user filter coefficient set arriving as a stream of 16-bit words on a register write path and turns it into entries in a coefficient RAM. Each coefficient occupies two consecutive words. The first word holds five zero pad bits, then the sign, then the ten upper magnitude bits. The second word holds the sixteen lower magnitude bits. The loader joins each pair into a 27-bit sign-magnitude value. It converts that value to two's complement and issues a one-cycle RAM write at the next free address, starting from zero.

While coefficients stream in, the loader keeps a running checksum of every coefficient word. After the last coefficient, the host writes a checksum word, flagged on the same path. A match raises the download-OK status, unless the stream held a malformed first word or more coefficients than the RAM holds. A second status bit, filter-OK, compares a checksum reported by the filter datapath as the coefficients pass through it against the downloaded checksum. A user-set flag tells the filter datapath to leave its reset-default coefficients. A start command begins a new download and clears all progress.

Top module: `coef_loader`

## Requirements
- R1: The first word of a coefficient carries the sign in bit 10 and magnitude bits 25..16 in bits 9..0. The second word carries magnitude bits 15..0. The clock edge that accepts the second word produces a one-cycle `coef_we` pulse. The pulse carries the two's complement value and an address that counts 0, 1, 2, ... from the last start.
- R2: A coefficient with the sign set and zero magnitude is written as all zeros.
- R3: The checksum is the 16-bit sum, with carries out of bit 15 dropped, of every coefficient word since the last start. A checksum word (`wr_is_csum`=1) equal to it sets `dl_ok` on the accepting edge, and also sets `user_sel`.
- R4: A checksum word that differs from the computed sum leaves `dl_ok` low.
- R5: A first word with any of bits 15..11 set raises `fmt_err`. While `fmt_err` is high, `dl_ok` stays low even if the checksum matches.
- R6: A coefficient completed after MAX_COEF coefficients have been stored raises `ovf` and produces no write. While `ovf` is high, `dl_ok` stays low.
- R7: `dl_start` clears the address counter, the checksum sum, the word pairing, `dl_ok`, `fmt_err`, `ovf`, `filter_ok` and `user_sel`. A word offered in the same cycle is ignored.
- R8: When `pass_valid` is high and a checksum word has been received since the last start, `filter_ok` takes the result of comparing `pass_csum` with the received checksum. Before any checksum word arrives, `pass_valid` leaves `filter_ok` low.
- R9: `user_sel` is low after reset. It stays high after a successful download until the next start, even if a later checksum word fails.
- R10: After reset, `coef_we`, `dl_ok`, `filter_ok`, `fmt_err`, `ovf` and `user_sel` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dl_start | input | 1 | Begin a new download; clears progress and status |
| wr_valid | input | 1 | A word is offered on `wr_data` this cycle |
| wr_is_csum | input | 1 | The offered word is the checksum, not a coefficient word |
| wr_data | input | 16 | Downloaded word |
| pass_valid | input | 1 | Datapath checksum is valid this cycle |
| pass_csum | input | 16 | Checksum generated by the filter datapath |
| coef_we | output | 1 | Coefficient RAM write strobe |
| coef_addr | output | ADDR_W | Coefficient RAM address |
| coef_wdata | output | 27 | Two's complement coefficient |
| dl_ok | output | 1 | Downloaded checksum matched the computed sum |
| filter_ok | output | 1 | Datapath checksum matched the downloaded checksum |
| fmt_err | output | 1 | A first word had nonzero pad bits |
| ovf | output | 1 | More coefficients than the RAM holds |
| user_sel | output | 1 | The user coefficient set is in force |

## Verification
The assertions assume that the host sends each coefficient as an adjacent pair of words, that a start command is a single-cycle pulse, and that a checksum word arrives only after a whole number of coefficients. The bench drives every word through one task that builds both halves of a coefficient from a sign and a magnitude. It raises `wr_is_csum` only between coefficients and pulses `dl_start` by itself. Malformed first words and surplus coefficients are injected on purpose through the same task, so the error flags are reached only by legal handshakes.

// File: rtl/coef_ld_pkg.sv
package coef_ld_pkg;
    localparam int WORD_W = 16;
    localparam int MAG_W  = 26;
    localparam int COEF_W = MAG_W + 1;
    localparam int PAD_W  = 5;
    localparam int HI_MAG = MAG_W - WORD_W;   // magnitude bits in first word
    localparam int SIGN_B = HI_MAG;           // sign position in first word

    function automatic logic [COEF_W-1:0] sm_to_tc(input logic s,
                                                   input logic [MAG_W-1:0] m);
        logic [COEF_W-1:0] ext;
        ext = {1'b0, m};
        if (s && (m != '0))
            return ~ext + COEF_W'(1);
        return ext;
    endfunction
endpackage

// File: rtl/coef_word_pair.sv
module coef_word_pair
    import coef_ld_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word,
    output logic              pair_valid,
    output logic [COEF_W-1:0] pair_coef,
    output logic              hdr_bad
);
    typedef struct packed {
        logic              phase;
        logic [WORD_W-1:0] hi;
    } pair_st_t;

    pair_st_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        pair_valid = 1'b0;
        pair_coef  = '0;
        hdr_bad    = 1'b0;
        if (clr) begin
            st_d = '0;
        end else if (word_valid) begin
            if (!st_q.phase) begin
                st_d.hi    = word;
                st_d.phase = 1'b1;
                hdr_bad    = |word[WORD_W-1 -: PAD_W];
            end else begin
                st_d.phase = 1'b0;
                pair_valid = 1'b1;
                pair_coef  = sm_to_tc(st_q.hi[SIGN_B],
                                      {st_q.hi[HI_MAG-1:0], word});
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1
    pair_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

    // R5
    hdr_first_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_bad |-> !pair_valid);
endmodule

// File: rtl/coef_csum.sv
module coef_csum
    import coef_ld_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add_valid,
    input  logic [WORD_W-1:0] add_word,
    input  logic              cmp_valid,
    input  logic [WORD_W-1:0] cmp_word,
    input  logic              pass_valid,
    input  logic [WORD_W-1:0] pass_csum,
    output logic              csum_match,
    output logic              filter_ok
);
    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [WORD_W-1:0] rx;
        logic              seen;
        logic              fok;
    } cs_st_t;

    cs_st_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        csum_match = cmp_valid && (cmp_word == st_q.acc);
        if (clr) begin
            st_d = '0;
        end else begin
            if (add_valid)
                st_d.acc = st_q.acc + add_word;
            if (cmp_valid) begin
                st_d.rx   = cmp_word;
                st_d.seen = 1'b1;
            end
            if (pass_valid && st_q.seen)
                st_d.fok = (pass_csum == st_q.rx);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filter_ok = st_q.fok;

    // R8
    fok_needs_csum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        filter_ok |-> st_q.seen);
endmodule

// File: rtl/coef_loader.sv
module coef_loader
    import coef_ld_pkg::*;
#(
    parameter int MAX_COEF = 96,
    localparam int ADDR_W  = $clog2(MAX_COEF),
    localparam int CNT_W   = $clog2(MAX_COEF + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dl_start,
    input  logic              wr_valid,
    input  logic              wr_is_csum,
    input  logic [15:0]       wr_data,
    input  logic              pass_valid,
    input  logic [15:0]       pass_csum,
    output logic              coef_we,
    output logic [ADDR_W-1:0] coef_addr,
    output logic [26:0]       coef_wdata,
    output logic              dl_ok,
    output logic              filter_ok,
    output logic              fmt_err,
    output logic              ovf,
    output logic              user_sel
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [COEF_W-1:0] wdata;
        logic              ok;
        logic              fe;
        logic              ov;
        logic              usr;
    } top_st_t;

    top_st_t st_q, st_d;

    logic              word_go, csum_go;
    logic              pair_valid, hdr_bad, csum_match;
    logic [COEF_W-1:0] pair_coef;

    assign word_go = wr_valid && !wr_is_csum && !dl_start;
    assign csum_go = wr_valid &&  wr_is_csum && !dl_start;

    coef_word_pair u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (dl_start),
        .word_valid (word_go),
        .word       (wr_data),
        .pair_valid (pair_valid),
        .pair_coef  (pair_coef),
        .hdr_bad    (hdr_bad)
    );

    coef_csum u_csum (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (dl_start),
        .add_valid  (word_go),
        .add_word   (wr_data),
        .cmp_valid  (csum_go),
        .cmp_word   (wr_data),
        .pass_valid (pass_valid),
        .pass_csum  (pass_csum),
        .csum_match (csum_match),
        .filter_ok  (filter_ok)
    );

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        if (dl_start) begin
            st_d = '0;
        end else begin
            if (hdr_bad) begin
                st_d.fe = 1'b1;
                st_d.ok = 1'b0;
            end
            if (pair_valid) begin
                if (st_q.cnt < CNT_W'(MAX_COEF)) begin
                    st_d.we    = 1'b1;
                    st_d.addr  = st_q.cnt[ADDR_W-1:0];
                    st_d.wdata = pair_coef;
                    st_d.cnt   = st_q.cnt + CNT_W'(1);
                end else begin
                    st_d.ov = 1'b1;
                    st_d.ok = 1'b0;
                end
            end
            if (csum_go) begin
                st_d.ok = csum_match && !st_q.fe && !st_q.ov;
                if (csum_match && !st_q.fe && !st_q.ov)
                    st_d.usr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign coef_we    = st_q.we;
    assign coef_addr  = st_q.addr;
    assign coef_wdata = st_q.wdata;
    assign dl_ok      = st_q.ok;
    assign fmt_err    = st_q.fe;
    assign ovf        = st_q.ov;
    assign user_sel   = st_q.usr;

    // R5
    fmt_blocks_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |-> !dl_ok);

    // R6
    ovf_blocks_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> !dl_ok);

    // R6
    ovf_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !dl_start) |=> !coef_we);

    // R7
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dl_start |=> !(dl_ok || fmt_err || ovf || filter_ok || user_sel || coef_we));

    // R9
    user_needs_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(user_sel) |-> dl_ok);

    // R1
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coef_we |-> (int'(coef_addr) < MAX_COEF));
endmodule

// File: tb/coef_loader_tb.sv
module coef_loader_tb;
    localparam int MAX = 8;
    localparam int AW  = $clog2(MAX);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dl_start = 1'b0, wr_valid = 1'b0, wr_is_csum = 1'b0;
    logic [15:0]   wr_data = '0;
    logic          pass_valid = 1'b0;
    logic [15:0]   pass_csum = '0;
    logic          coef_we, dl_ok, filter_ok, fmt_err, ovf, user_sel;
    logic [AW-1:0] coef_addr;
    logic [26:0]   coef_wdata;

    int checks = 0, errors = 0;
    logic [15:0] sum;
    int          nstored;
    logic [AW-1:0] exp_addr_q[$];
    logic [26:0]   exp_data_q[$];

    always #2 clk = ~clk;   // 250 MHz

    coef_loader #(.MAX_COEF(MAX)) u_dut (
        .clk(clk), .rst_n(rst_n), .dl_start(dl_start), .wr_valid(wr_valid),
        .wr_is_csum(wr_is_csum), .wr_data(wr_data), .pass_valid(pass_valid),
        .pass_csum(pass_csum), .coef_we(coef_we), .coef_addr(coef_addr),
        .coef_wdata(coef_wdata), .dl_ok(dl_ok), .filter_ok(filter_ok),
        .fmt_err(fmt_err), .ovf(ovf), .user_sel(user_sel));

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops scoreboard on every RAM write (R1, R2, R7)
    always @(negedge clk) begin
        if (rst_n && coef_we) begin
            if (exp_addr_q.size() == 0) begin
                check(1'b0, "R6 unexpected write", 32'(coef_addr), 32'hffff);
            end else begin
                logic [AW-1:0] ea;
                logic [26:0]   ed;
                ea = exp_addr_q.pop_front();
                ed = exp_data_q.pop_front();
                check(coef_addr == ea, "R1 R7 write address", 32'(coef_addr), 32'(ea));
                check(coef_wdata == ed, "R1 R2 write data", 32'(coef_wdata), 32'(ed));
            end
        end
    end

    task automatic put_word(input logic is_cs, input logic [15:0] w);
        @(negedge clk);
        wr_valid = 1'b1; wr_is_csum = is_cs; wr_data = w;
        @(negedge clk);
        wr_valid = 1'b0; wr_is_csum = 1'b0;
    endtask

    // Driver: sends one coefficient with a given pad field, pushes expectation
    task automatic send_coef(input logic [4:0] pad, input logic s,
                             input logic [25:0] m);
        logic [15:0] w0, w1;
        logic [26:0] e;
        w0 = {pad, s, m[25:16]};
        w1 = m[15:0];
        e  = s ? (27'd0 - {1'b0, m}) : {1'b0, m};
        sum = sum + w0 + w1;
        if (nstored < MAX) begin
            exp_addr_q.push_back(AW'(nstored));
            exp_data_q.push_back(e);
            nstored++;
        end
        put_word(1'b0, w0);
        put_word(1'b0, w1);
    endtask

    task automatic start_dl();
        @(negedge clk);
        dl_start = 1'b1;
        @(negedge clk);
        dl_start = 1'b0;
        sum = '0; nstored = 0;
    endtask

    task automatic pass(input logic [15:0] v);
        @(negedge clk);
        pass_valid = 1'b1; pass_csum = v;
        @(negedge clk);
        pass_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        sum = '0; nstored = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check({coef_we, dl_ok, filter_ok, fmt_err, ovf, user_sel} == 6'b0,
              "R10 reset flags", 32'({coef_we, dl_ok, filter_ok, fmt_err, ovf, user_sel}), 0);

        // Good download: mixed signs, negative zero, extremes
        start_dl();
        pass(16'h0000);
        check(filter_ok == 1'b0, "R8 pass before checksum", 32'(filter_ok), 0);
        send_coef(5'd0, 1'b0, 26'd5);
        send_coef(5'd0, 1'b1, 26'd5);
        send_coef(5'd0, 1'b1, 26'd0);           // R2 negative zero
        send_coef(5'd0, 1'b0, 26'h3ffffff);
        send_coef(5'd0, 1'b1, 26'h3ffffff);
        send_coef(5'd0, 1'b1, 26'h2a5c3e1);
        put_word(1'b1, sum);
        check(dl_ok == 1'b1, "R3 checksum match", 32'(dl_ok), 1);
        check(user_sel == 1'b1, "R9 user set after good download", 32'(user_sel), 1);
        check(fmt_err == 1'b0 && ovf == 1'b0, "R3 no error flags", 32'({fmt_err, ovf}), 0);
        pass(sum);
        check(filter_ok == 1'b1, "R8 datapath checksum equal", 32'(filter_ok), 1);
        pass(sum ^ 16'h0100);
        check(filter_ok == 1'b0, "R8 datapath checksum differs", 32'(filter_ok), 0);
        put_word(1'b1, sum + 16'd1);
        check(dl_ok == 1'b0, "R4 later bad checksum", 32'(dl_ok), 0);
        check(user_sel == 1'b1, "R9 user_sel sticky", 32'(user_sel), 1);

        // Restart clears all, addresses restart at 0
        start_dl();
        check({dl_ok, filter_ok, fmt_err, ovf, user_sel} == 5'b0,
              "R7 start clears status", 32'({dl_ok, filter_ok, fmt_err, ovf, user_sel}), 0);
        @(negedge clk);
        dl_start = 1'b1; wr_valid = 1'b1; wr_data = 16'h1234;   // R7 ignored word
        @(negedge clk);
        dl_start = 1'b0; wr_valid = 1'b0;
        sum = '0; nstored = 0;
        send_coef(5'd0, 1'b0, 26'h0010001);
        send_coef(5'd0, 1'b1, 26'h0000300);
        put_word(1'b1, sum ^ 16'h8000);
        check(dl_ok == 1'b0, "R4 checksum mismatch", 32'(dl_ok), 0);
        check(user_sel == 1'b0, "R9 no user set on mismatch", 32'(user_sel), 0);
        put_word(1'b1, sum);
        check(dl_ok == 1'b1, "R3 R7 sum restarted at start", 32'(dl_ok), 1);

        // Format error
        start_dl();
        send_coef(5'd0, 1'b0, 26'd7);
        send_coef(5'b00100, 1'b0, 26'd9);
        check(fmt_err == 1'b1, "R5 pad bits set", 32'(fmt_err), 1);
        put_word(1'b1, sum);
        check(dl_ok == 1'b0, "R5 ok blocked by format error", 32'(dl_ok), 0);
        check(user_sel == 1'b0, "R5 R9 no user set", 32'(user_sel), 0);

        // Overflow: MAX+1 coefficients
        start_dl();
        for (int i = 0; i < MAX; i++) send_coef(5'd0, i[0], 26'(i * 1000 + 3));
        check(ovf == 1'b0, "R6 full but not over", 32'(ovf), 0);
        send_coef(5'd0, 1'b0, 26'd11);
        check(ovf == 1'b1, "R6 extra coefficient", 32'(ovf), 1);
        put_word(1'b1, sum);
        check(dl_ok == 1'b0, "R6 ok blocked by overflow", 32'(dl_ok), 0);

        repeat (4) @(negedge clk);
        check(exp_addr_q.size() == 0, "R1 all expected writes seen",
              32'(exp_addr_q.size()), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule